// File: doc/BRIEF.md
# AAL1 Residual Time Stamp Bit Inserter

This block sits on the transmit side of an AAL1 adaptation path. It decides, for each outgoing cell, the value of the convergence-sublayer indication (CSI) bit in the sequence-number field. Outside structured signalling operation, a small code from external clock-recovery timing logic is sampled when the cell with sequence count 1 starts. That code is then spread one bit per cell over the four odd-numbered cells of the 8-cell sequence cycle, most significant bit first.

When the channel runs in signalling (CAS) mode, the holding field serves another purpose. No code is sampled, the CSI bit stays 0, and any partly sent code is dropped. Control is a two-state machine. `ST_IDLE` means no code is being carried. `ST_ARMED` means a code is held and the next odd count that should carry a bit is known. Its transitions are:
- T_LOAD: count 1 outside CAS mode, from either state, goes to `ST_ARMED`.
- T_ADVANCE: the expected odd count arrives, so the machine stays armed and the expected count moves up by 2.
- T_DONE: count 7 is carried, and the machine returns to `ST_IDLE`.
- T_ABORT: a CAS-mode cell, or an odd count other than the expected one, returns the machine to `ST_IDLE`.
- T_HOLD: an even count, or no cell start, leaves the state as it is.

The CSI bit is registered on the clock edge where `cell_start` is high. It stays constant until the next cell start. Computing the code, protecting the sequence-number field and building the payload are handled elsewhere.

Top module: `aal1_srts_inserter`

## Requirements
- R1: After synchronous active-low reset, `csi_bit` is 0, the held code is 0, and the machine carries no code, so an odd cell other than count 1 yields `csi_bit` 0.
- R2: `ts_sample` is 1 exactly while `cell_start` is 1, `seq_cnt` is 1 and `cas_mode` is 0; otherwise it is 0.
- R3: At the edge of a count-1 cell start outside CAS mode, `ts_code` is latched, and from the next cycle `csi_bit` equals `ts_code[3]` of that edge.
- R4: Counts 3, 5 and 7, arriving in that order after a count-1 cell, carry held code bits 2, 1 and 0 respectively on `csi_bit`.
- R5: A cell with an even `seq_cnt` (bit 0 equal to 0) gives `csi_bit` 0.
- R6: A cell started with `cas_mode` 1 gives `csi_bit` 0, takes no sample, and drops any carried code. Later odd cells give 0 until the next count-1 cell.
- R7: A new count-1 cell replaces the held code and restarts the spreading at count 3.
- R8: `csi_bit` changes only at edges where `cell_start` is 1.
- R9: An odd count other than the expected one (3, 5, then 7) gives `csi_bit` 0 and drops the carried code.
- R10: Changes of `ts_code` after the sample have no effect on the bits carried by counts 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_start | input | 1 | One-cycle strobe at the start of each outgoing cell |
| seq_cnt | input | SN_W (3) | Sequence count of the cell being started |
| cas_mode | input | 1 | 1 = signalling mode, no code insertion |
| ts_code | input | CODE_W (4) | Code from external timing logic |
| ts_sample | output | 1 | Strobe telling the timing logic its code is taken this cycle |
| csi_bit | output | 1 | CSI bit for the current cell |

## Verification
The bench builds the block with the default `SN_W` of 3, which gives a 4-bit code and four odd slots per 8-cell cycle. With that width, every slot ordering, wrap-around at count 7, a skipped odd count and a mid-code switch into signalling mode can be reached in a few dozen cells. Several code patterns (alternating bits, all ones, all zeros, single bits) put each held bit position to the test on its own.

// File: rtl/aal1_srts_pkg.sv
package aal1_srts_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } srts_state_e;

endpackage

// File: rtl/srts_sequencer.sv
module srts_sequencer
    import aal1_srts_pkg::*;
#(
    parameter int SN_W = 3,
    localparam int IDX_W = SN_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_start,
    input  logic [SN_W-1:0]  seq_cnt,
    input  logic             cas_mode,
    output logic             load,
    output logic             emit,
    output logic [IDX_W-1:0] bit_sel
);

    localparam logic [SN_W-1:0] SN_ONE   = SN_W'(1);
    localparam logic [SN_W-1:0] SN_THREE = SN_W'(3);
    localparam logic [SN_W-1:0] SN_LAST  = '1;

    srts_state_e     state_q, state_d;
    logic [SN_W-1:0] next_odd_q, next_odd_d;
    logic            is_odd, is_one, hit;

    assign is_odd = seq_cnt[0];
    assign is_one = (seq_cnt == SN_ONE);
    assign hit    = (state_q == ST_ARMED) && is_odd && !is_one
                    && (seq_cnt == next_odd_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            next_odd_q <= SN_THREE;
        end else begin
            state_q    <= state_d;
            next_odd_q <= next_odd_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        next_odd_d = next_odd_q;
        if (cell_start) begin
            if (cas_mode) begin
                state_d = ST_IDLE;                      // T_ABORT
            end else if (is_one) begin
                state_d    = ST_ARMED;                  // T_LOAD
                next_odd_d = SN_THREE;
            end else if (is_odd) begin
                unique case (state_q)
                    ST_IDLE:  state_d = ST_IDLE;
                    ST_ARMED: begin
                        if (!hit) begin
                            state_d = ST_IDLE;          // T_ABORT
                        end else if (seq_cnt == SN_LAST) begin
                            state_d = ST_IDLE;          // T_DONE
                        end else begin
                            next_odd_d = next_odd_q + SN_W'(2); // T_ADVANCE
                        end
                    end
                    default:  state_d = ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        load    = cell_start && !cas_mode && is_one;
        emit    = cell_start && !cas_mode && hit;
        bit_sel = ~seq_cnt[SN_W-1:1];
    end

    // R9: a mismatching odd count always leaves the machine idle
    a_r9_abort_on_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start && !cas_mode && is_odd && !is_one && seq_cnt != next_odd_q)
        |=> (state_q == ST_IDLE));

    // R6: a signalling-mode cell always leaves the machine idle
    a_r6_cas_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start && cas_mode) |=> (state_q == ST_IDLE));

    a_r4_odd_expected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> next_odd_q[0]);

endmodule

// File: rtl/srts_hold.sv
module srts_hold #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= code_in;
        end
    end

    // R10: the held code moves only on a sample
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));

endmodule

// File: rtl/srts_csi_out.sv
module srts_csi_out #(
    parameter int CODE_W = 4,
    localparam int IDX_W = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_start,
    input  logic              load,
    input  logic              emit,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CODE_W-1:0] code_q,
    output logic              csi_q
);

    logic csi_d;

    always_comb begin
        if (load) begin
            csi_d = code_in[CODE_W-1];
        end else if (emit) begin
            csi_d = code_q[bit_sel];
        end else begin
            csi_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csi_q <= 1'b0;
        end else if (cell_start) begin
            csi_q <= csi_d;
        end
    end

    // R8: output held between cell starts
    a_r8_csi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_start |=> $stable(csi_q));

endmodule

// File: rtl/aal1_srts_inserter.sv
module aal1_srts_inserter #(
    parameter int SN_W = 3,
    localparam int CODE_W = 1 << (SN_W - 1),
    localparam int IDX_W = SN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_start,
    input  logic [SN_W-1:0]   seq_cnt,
    input  logic              cas_mode,
    input  logic [CODE_W-1:0] ts_code,
    output logic              ts_sample,
    output logic              csi_bit
);

    logic              load, emit;
    logic [IDX_W-1:0]  bit_sel;
    logic [CODE_W-1:0] code_q;

    srts_sequencer #(.SN_W(SN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .seq_cnt    (seq_cnt),
        .cas_mode   (cas_mode),
        .load       (load),
        .emit       (emit),
        .bit_sel    (bit_sel)
    );

    srts_hold #(.CODE_W(CODE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .code_in (ts_code),
        .code_q  (code_q)
    );

    srts_csi_out #(.CODE_W(CODE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .load       (load),
        .emit       (emit),
        .bit_sel    (bit_sel),
        .code_in    (ts_code),
        .code_q     (code_q),
        .csi_q      (csi_bit)
    );

    assign ts_sample = load;

    // R5: even count gives a zero bit
    a_r5_even_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start && !seq_cnt[0]) |=> !csi_bit);

    // R6: signalling-mode cell gives a zero bit
    a_r6_cas_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start && cas_mode) |=> !csi_bit);

    // R3: count-1 cell carries the sampled top bit
    a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start && !cas_mode && seq_cnt == SN_W'(1))
        |=> (csi_bit == $past(ts_code[CODE_W-1])));

    // R2: no sample without a cell start
    a_r2_sample_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ts_sample |-> (cell_start && !cas_mode));

endmodule

// File: tb/test_aal1_srts_inserter.sv
module test_aal1_srts_inserter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cell_start = 1'b0;
    logic [2:0] seq_cnt = '0;
    logic       cas_mode = 1'b0;
    logic [3:0] ts_code = '0;
    logic       ts_sample;
    logic       csi_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference state
    bit       m_armed = 1'b0;
    int       m_next  = 3;
    bit [3:0] m_hold  = '0;

    always #2 clk = ~clk;

    aal1_srts_inserter i_aal1_srts_inserter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .seq_cnt    (seq_cnt),
        .cas_mode   (cas_mode),
        .ts_code    (ts_code),
        .ts_sample  (ts_sample),
        .csi_bit    (csi_bit)
    );

    task automatic ck(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cell_start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_armed = 1'b0; m_next = 3; m_hold = '0;
    endtask

    // start one cell and check sample strobe and CSI bit
    task automatic send_cell(int seq, bit cas, bit [3:0] ts, string req);
        bit exp_csi;
        bit exp_smp;
        exp_smp = !cas && seq == 1;
        if (cas) begin
            exp_csi = 1'b0; m_armed = 1'b0;
        end else if (seq == 1) begin
            exp_csi = ts[3]; m_hold = ts; m_armed = 1'b1; m_next = 3;
        end else if (seq % 2 == 1) begin
            if (m_armed && seq == m_next) begin
                exp_csi = m_hold[3 - seq / 2];
                if (seq == 7) m_armed = 1'b0;
                else m_next = m_next + 2;
            end else begin
                exp_csi = 1'b0; m_armed = 1'b0;
            end
        end else begin
            exp_csi = 1'b0;
        end
        @(negedge clk);
        cell_start = 1'b1; seq_cnt = 3'(seq); cas_mode = cas; ts_code = ts;
        #1 ck("R2", ts_sample, exp_smp);
        @(negedge clk);
        cell_start = 1'b0;
        #1 ck(req, csi_bit, exp_csi);
        ck("R2", ts_sample, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        #1 ck("R1", csi_bit, 1'b0);
        ck("R1", ts_sample, 1'b0);
        send_cell(3, 1'b0, 4'hF, "R1");
        send_cell(5, 1'b0, 4'hF, "R1");
    endtask

    task automatic t_frame(bit [3:0] code);
        for (int s = 0; s < 8; s++) begin
            if (s == 1)          send_cell(s, 1'b0, code, "R3");
            else if (s % 2 == 1) send_cell(s, 1'b0, ~code, "R4");
            else                 send_cell(s, 1'b0, code, "R5");
        end
    endtask

    task automatic t_ts_change();
        send_cell(1, 1'b0, 4'b0110, "R3");
        send_cell(2, 1'b0, 4'b1001, "R10");
        send_cell(3, 1'b0, 4'b1001, "R10");
        send_cell(4, 1'b0, 4'b0000, "R10");
        send_cell(5, 1'b0, 4'b0000, "R10");
        send_cell(6, 1'b0, 4'b1111, "R10");
        send_cell(7, 1'b0, 4'b1111, "R10");
    endtask

    task automatic t_cas();
        send_cell(0, 1'b1, 4'hF, "R6");
        send_cell(1, 1'b1, 4'hF, "R6");
        send_cell(3, 1'b0, 4'hF, "R6");
        send_cell(5, 1'b0, 4'hF, "R6");
        send_cell(1, 1'b0, 4'hF, "R3");
        send_cell(3, 1'b0, 4'hF, "R4");
        send_cell(5, 1'b1, 4'hF, "R6");
        send_cell(7, 1'b0, 4'hF, "R6");
    endtask

    task automatic t_skip();
        send_cell(1, 1'b0, 4'b1111, "R3");
        send_cell(2, 1'b0, 4'b1111, "R5");
        send_cell(5, 1'b0, 4'b1111, "R9");
        send_cell(7, 1'b0, 4'b1111, "R9");
        send_cell(1, 1'b0, 4'b0111, "R3");
        send_cell(7, 1'b0, 4'b0111, "R9");
    endtask

    task automatic t_reload();
        send_cell(1, 1'b0, 4'b1110, "R3");
        send_cell(3, 1'b0, 4'b0000, "R4");
        send_cell(1, 1'b0, 4'b0011, "R7");
        send_cell(3, 1'b0, 4'b0000, "R7");
        send_cell(5, 1'b0, 4'b0000, "R7");
        send_cell(7, 1'b0, 4'b0000, "R7");
    endtask

    task automatic t_stable();
        send_cell(1, 1'b0, 4'b1000, "R3");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seq_cnt = 3'(k); ts_code = 4'(k); cas_mode = k[0];
            #1 ck("R8", csi_bit, 1'b1);
            ck("R2", ts_sample, 1'b0);
        end
        cas_mode = 1'b0;
        send_cell(3, 1'b0, 4'b0000, "R4");
        repeat (3) begin
            @(negedge clk);
            #1 ck("R8", csi_bit, 1'b0);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_frame(4'b1010);
                t_frame(4'b0101);
                t_frame(4'b1111);
                t_frame(4'b0000);
                t_frame(4'b0100);
                t_frame(4'b0010);
                t_ts_change();
                t_cas();
                t_skip();
                t_reload();
                t_stable();
                t_reset();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; fails++;
                    $display("FAIL watchdog: actual hung expected finished");
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule